// File: doc/BRIEF.md
# Inter-Processor Mailbox Controller

This block lets several processor channels pass short fixed-length messages to each other through memory-mapped mailboxes. Each mailbox holds an owner mask, a destination mask, an interrupt-enable mask, a handshake control word and seven 32-bit payload words. A channel claims a mailbox by writing its one-hot code into the owner register. It fills in the payload and destinations and then posts the message. The destination channels take an interrupt, read the payload and answer with an acknowledge. The acknowledge moves the interrupt back to the owner.

Software sees one register bus with address, write data, read data and write/read strobes. Each channel has a level interrupt output. For every channel there is a pair of status words, one filtered by the mailbox masks and one unfiltered. Bit n of each word reports mailbox n. Mask and destination registers have separate set and clear addresses, so channels can update single bits without a read-modify-write.

Top module: `ipc_mailbox_hub`

## Requirements
- R1: After reset every mailbox register reads zero, every status word reads zero, `chan_irq` is all zero and `bus_rdata` is zero.
- R2: Mailbox m sits at byte address m*0x40. Word offsets inside the window are: owner 0x00, destination set 0x04, destination clear 0x08, destination value 0x0C, mode 0x10 (always reads zero), mask set 0x14, mask clear 0x18, mask value 0x1C, control 0x20, and payload word k at 0x24+4k for k=0..6. A read strobe at one rising edge puts the value on `bus_rdata` after that edge. In any cycle that follows an edge with no read strobe, `bus_rdata` is zero.
- R3: A write to the owner register takes effect only while it reads zero. Writing zero always releases the mailbox.
- R4: While the owner register is zero, writes to the destination, mask, payload and control registers of that mailbox have no effect.
- R5: A set address ORs the written channel bits into its register. A clear address removes the written bits. This holds for both the destination and the mask registers.
- R6: Writing 1 to the control register posts the message: for each channel in the destination register, that mailbox's raw status bit goes high.
- R7: Writing 2 to the control register acknowledges: the destination channels' raw bits drop and the owner channel's raw bit for that mailbox goes high.
- R8: Writing 0 to the control register returns it to idle and withdraws every raw bit of that mailbox. Any other value leaves the control register unchanged. The control register reads back 0, 1 or 2.
- R9: The masked status of channel c is at 0x800+8c and the raw status at 0x804+8c, with bit n for mailbox n. A masked bit is the raw bit ANDed with that channel's bit in the mailbox's mask register. The raw word ignores the mask.
- R10: `chan_irq[c]` is the OR of channel c's masked status bits. It follows a control or mask write starting in the cycle after that write's clock edge.
- R11: Reads of unmapped addresses return zero, and writes to them change nothing. Unmapped addresses are: misaligned addresses, mailbox windows at or beyond the mailbox count, the mode word, status words of nonexistent channels, and all other gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (12) | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| chan_irq | output | NUM_CHAN (8) | Per-channel interrupt level |

## Verification
A register write lands on the rising edge where the strobe is high. The interrupt lines and both status words derive from registered state with no further register, so they are correct in the low phase right after that edge. A read returns its data one edge after the strobe, through one register. The bench drives every access on a falling edge and samples interrupts and read data on the next falling edge, so each check sees exactly one register stage between stimulus and result.

// File: rtl/ipc_mbx_pkg.sv
package ipc_mbx_pkg;

  localparam int WIN_SH      = 6;
  localparam int WIN_BYTES   = 1 << WIN_SH;
  localparam int WORD_W      = WIN_SH - 2;
  localparam int DATA_FIRST  = 9;
  localparam int DATA_WORDS  = (1 << WORD_W) - DATA_FIRST;
  localparam int DW_W        = $clog2(DATA_WORDS);
  localparam int STAT_BASE   = 'h800;
  localparam int STAT_STRIDE = 8;

  localparam logic [1:0] SEND_IDLE = 2'd0;
  localparam logic [1:0] SEND_MSG  = 2'd1;
  localparam logic [1:0] SEND_ACK  = 2'd2;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_SRC, SEL_DSET, SEL_DCLR, SEL_DSTAT,
    SEL_MSET, SEL_MCLR, SEL_MSTAT, SEL_SEND, SEL_DATA
  } reg_sel_e;

  // Raw status contribution of one mailbox toward one channel.
  function automatic logic route_bit(input logic [1:0] st, input logic own, input logic dst);
    return ((st == SEND_MSG) && dst) || ((st == SEND_ACK) && own);
  endfunction

  // Control words that are accepted: 0, 1, 2.
  function automatic logic send_code_ok(input logic [31:0] w);
    return w <= 32'd2;
  endfunction

endpackage

// File: rtl/mbx_addr_decode.sv
module mbx_addr_decode
  import ipc_mbx_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int NUM_MBOX = 8,
  parameter int NUM_CHAN = 8,
  localparam int MB_W = (NUM_MBOX > 1) ? $clog2(NUM_MBOX) : 1,
  localparam int CH_W = (NUM_CHAN > 1) ? $clog2(NUM_CHAN) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              mbx_hit,
  output logic [MB_W-1:0]   mbx_idx,
  output reg_sel_e          sel,
  output logic [DW_W-1:0]   data_idx,
  output logic              stat_hit,
  output logic [CH_W-1:0]   stat_chan,
  output logic              stat_raw
);

  logic              aligned;
  logic [WORD_W-1:0] word;
  logic [31:0]       a32;
  logic [31:0]       stat_off;

  always_comb begin
    a32      = 32'(addr);
    aligned  = (addr[1:0] == 2'b00);
    mbx_hit  = aligned && (a32 < 32'(NUM_MBOX * WIN_BYTES));
    mbx_idx  = MB_W'(addr >> WIN_SH);
    word     = addr[WIN_SH-1:2];
    sel      = SEL_NONE;
    data_idx = '0;
    if (mbx_hit) begin
      case (word)
        4'd0:    sel = SEL_SRC;
        4'd1:    sel = SEL_DSET;
        4'd2:    sel = SEL_DCLR;
        4'd3:    sel = SEL_DSTAT;
        4'd5:    sel = SEL_MSET;
        4'd6:    sel = SEL_MCLR;
        4'd7:    sel = SEL_MSTAT;
        4'd8:    sel = SEL_SEND;
        default: sel = SEL_NONE;
      endcase
      if (word >= WORD_W'(DATA_FIRST)) begin
        sel      = SEL_DATA;
        data_idx = DW_W'(word - WORD_W'(DATA_FIRST));
      end
    end
    stat_off  = a32 - 32'(STAT_BASE);
    stat_hit  = aligned && (a32 >= 32'(STAT_BASE)) &&
                (a32 < 32'(STAT_BASE + STAT_STRIDE * NUM_CHAN));
    stat_chan = CH_W'(stat_off >> 3);
    stat_raw  = addr[2];
  end

endmodule

// File: rtl/mbx_slot.sv
module mbx_slot
  import ipc_mbx_pkg::*;
#(
  parameter int NUM_CHAN = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  reg_sel_e                     sel,
  input  logic [DW_W-1:0]              data_idx,
  input  logic [31:0]                  wdata,
  output logic [NUM_CHAN-1:0]          src_q,
  output logic [NUM_CHAN-1:0]          dst_q,
  output logic [NUM_CHAN-1:0]          msk_q,
  output logic [1:0]                   send_q,
  output logic [DATA_WORDS-1:0][31:0]  data_q,
  output logic                         send_fire,
  output logic                         ack_fire
);

  logic                owned;
  logic                owned_wr;
  logic                src_take;
  logic                ctl_ok;
  logic [NUM_CHAN-1:0] wbits;

  assign wbits     = wdata[NUM_CHAN-1:0];
  assign owned     = (src_q != '0);
  assign owned_wr  = wr_en && owned;
  assign src_take  = wr_en && (sel == SEL_SRC) && (!owned || (wbits == '0));
  assign ctl_ok    = owned_wr && (sel == SEL_SEND) && send_code_ok(wdata);
  assign send_fire = ctl_ok && (wdata[1:0] == SEND_MSG);
  assign ack_fire  = ctl_ok && (wdata[1:0] == SEND_ACK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      dst_q  <= '0;
      msk_q  <= '0;
      send_q <= SEND_IDLE;
      data_q <= '0;
    end else begin
      if (src_take) src_q <= wbits;
      if (owned_wr) begin
        case (sel)
          SEL_DSET: dst_q <= dst_q | wbits;
          SEL_DCLR: dst_q <= dst_q & ~wbits;
          SEL_MSET: msk_q <= msk_q | wbits;
          SEL_MCLR: msk_q <= msk_q & ~wbits;
          SEL_DATA: data_q[data_idx] <= wdata;
          default:  ;
        endcase
      end
      if (ctl_ok) send_q <= wdata[1:0];
    end
  end

endmodule

// File: rtl/mbx_irq_route.sv
module mbx_irq_route
  import ipc_mbx_pkg::*;
#(
  parameter int NUM_MBOX = 8,
  parameter int NUM_CHAN = 8
) (
  input  logic [NUM_MBOX-1:0][NUM_CHAN-1:0] src_q,
  input  logic [NUM_MBOX-1:0][NUM_CHAN-1:0] dst_q,
  input  logic [NUM_MBOX-1:0][NUM_CHAN-1:0] msk_q,
  input  logic [NUM_MBOX-1:0][1:0]          send_q,
  output logic [NUM_CHAN-1:0][NUM_MBOX-1:0] raw_st,
  output logic [NUM_CHAN-1:0][NUM_MBOX-1:0] msk_st,
  output logic [NUM_CHAN-1:0]               chan_irq
);

  always_comb begin
    for (int c = 0; c < NUM_CHAN; c++) begin
      for (int m = 0; m < NUM_MBOX; m++) begin
        raw_st[c][m] = route_bit(send_q[m], src_q[m][c], dst_q[m][c]);
        msk_st[c][m] = raw_st[c][m] && msk_q[m][c];
      end
      chan_irq[c] = |msk_st[c];
    end
  end

endmodule

// File: rtl/ipc_mailbox_hub.sv
module ipc_mailbox_hub
  import ipc_mbx_pkg::*;
#(
  parameter int NUM_MBOX = 8,
  parameter int NUM_CHAN = 8,
  parameter int ADDR_W   = 12,
  localparam int MB_W = (NUM_MBOX > 1) ? $clog2(NUM_MBOX) : 1,
  localparam int CH_W = (NUM_CHAN > 1) ? $clog2(NUM_CHAN) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [31:0]         bus_wdata,
  input  logic                bus_wr,
  input  logic                bus_rd,
  output logic [31:0]         bus_rdata,
  output logic [NUM_CHAN-1:0] chan_irq
);

  logic            mbx_hit;
  logic [MB_W-1:0] mbx_idx;
  reg_sel_e        wr_sel;
  logic [DW_W-1:0] data_idx;
  logic            stat_hit;
  logic [CH_W-1:0] stat_chan;
  logic            stat_raw;

  logic [NUM_MBOX-1:0][NUM_CHAN-1:0]          src_q, dst_q, msk_q;
  logic [NUM_MBOX-1:0][1:0]                   send_q;
  logic [NUM_MBOX-1:0][DATA_WORDS-1:0][31:0]  data_q;
  logic [NUM_MBOX-1:0]                        mbx_wr, send_fire, ack_fire;
  logic [NUM_CHAN-1:0][NUM_MBOX-1:0]          raw_st, msk_st;
  logic [31:0]                                rd_val;

  mbx_addr_decode #(.ADDR_W(ADDR_W), .NUM_MBOX(NUM_MBOX), .NUM_CHAN(NUM_CHAN)) u_dec (
    .addr(bus_addr), .mbx_hit(mbx_hit), .mbx_idx(mbx_idx), .sel(wr_sel),
    .data_idx(data_idx), .stat_hit(stat_hit), .stat_chan(stat_chan), .stat_raw(stat_raw)
  );

  for (genvar m = 0; m < NUM_MBOX; m++) begin : g_slot
    assign mbx_wr[m] = bus_wr && mbx_hit && (mbx_idx == MB_W'(m));
    mbx_slot #(.NUM_CHAN(NUM_CHAN)) u_slot (
      .clk(clk), .rst_n(rst_n), .wr_en(mbx_wr[m]), .sel(wr_sel),
      .data_idx(data_idx), .wdata(bus_wdata),
      .src_q(src_q[m]), .dst_q(dst_q[m]), .msk_q(msk_q[m]), .send_q(send_q[m]),
      .data_q(data_q[m]), .send_fire(send_fire[m]), .ack_fire(ack_fire[m])
    );
  end

  mbx_irq_route #(.NUM_MBOX(NUM_MBOX), .NUM_CHAN(NUM_CHAN)) u_route (
    .src_q(src_q), .dst_q(dst_q), .msk_q(msk_q), .send_q(send_q),
    .raw_st(raw_st), .msk_st(msk_st), .chan_irq(chan_irq)
  );

  always_comb begin
    rd_val = '0;
    if (stat_hit) begin
      rd_val = stat_raw ? 32'(raw_st[stat_chan]) : 32'(msk_st[stat_chan]);
    end else if (mbx_hit) begin
      case (wr_sel)
        SEL_SRC:   rd_val = 32'(src_q[mbx_idx]);
        SEL_DSTAT: rd_val = 32'(dst_q[mbx_idx]);
        SEL_MSTAT: rd_val = 32'(msk_q[mbx_idx]);
        SEL_SEND:  rd_val = 32'(send_q[mbx_idx]);
        SEL_DATA:  rd_val = data_q[mbx_idx][data_idx];
        default:   rd_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= '0;
    else        bus_rdata <= bus_rd ? rd_val : '0;
  end

endmodule

// File: rtl/ipc_mbx_chk.sv
module ipc_mbx_chk
  import ipc_mbx_pkg::*;
#(
  parameter int NUM_MBOX = 8,
  parameter int NUM_CHAN = 8
) (
  input logic                              clk,
  input logic                              rst_n,
  input logic                              bus_rd,
  input logic [31:0]                       bus_wdata,
  input logic [31:0]                       bus_rdata,
  input logic [NUM_CHAN-1:0]               chan_irq,
  input logic [NUM_MBOX-1:0]               mbx_wr,
  input reg_sel_e                          wr_sel,
  input logic [NUM_MBOX-1:0][NUM_CHAN-1:0] src_q,
  input logic [NUM_MBOX-1:0][NUM_CHAN-1:0] dst_q,
  input logic [NUM_MBOX-1:0][NUM_CHAN-1:0] msk_q,
  input logic [NUM_MBOX-1:0][1:0]          send_q,
  input logic [NUM_MBOX-1:0]               send_fire,
  input logic [NUM_MBOX-1:0]               ack_fire
);

  // R11
  one_mbx_wr_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(mbx_wr));

  // R2
  rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) !bus_rd |=> bus_rdata == '0);

  // R10
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) (send_q == '0) |-> (chan_irq == '0));

  for (genvar m = 0; m < NUM_MBOX; m++) begin : g_mb
    // R3
    own_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mbx_wr[m] && wr_sel == SEL_SRC && src_q[m] != '0 && bus_wdata[NUM_CHAN-1:0] != '0)
      |=> $stable(src_q[m]));
    // R4
    no_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mbx_wr[m] && wr_sel != SEL_SRC && src_q[m] == '0)
      |=> ($stable(dst_q[m]) && $stable(msk_q[m]) && $stable(send_q[m])));
    // R6
    post_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      send_fire[m] |=> send_q[m] == SEND_MSG);
    // R7
    ack_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack_fire[m] |=> send_q[m] == SEND_ACK);
    // R8
    ctl_legal_chk: assert property (@(posedge clk) disable iff (!rst_n) send_q[m] != 2'd3);
  end

endmodule

bind ipc_mailbox_hub ipc_mbx_chk #(.NUM_MBOX(NUM_MBOX), .NUM_CHAN(NUM_CHAN)) u_chk (.*);

// File: tb/tb_ipc_mailbox_hub.sv
module tb_ipc_mailbox_hub;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic [7:0]  chan_irq;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  ipc_mailbox_hub dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .chan_irq(chan_irq)
  );

  function automatic logic [11:0] mb(input int m, input int off);
    return 12'(m * 64 + off);
  endfunction
  function automatic logic [11:0] st_msk(input int c);
    return 12'('h800 + 8 * c);
  endfunction
  function automatic logic [11:0] st_raw(input int c);
    return 12'('h804 + 8 * c);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic t_reset;
    chk("R1 irq", 32'(chan_irq), 32'h0);
    chk("R1 rdata", bus_rdata, 32'h0);
    rd_chk("R1 owner mb0", mb(0, 'h00), 32'h0);
    rd_chk("R1 data mb7", mb(7, 'h3C), 32'h0);
    rd_chk("R1 masked ch0", st_msk(0), 32'h0);
    rd_chk("R1 raw ch7", st_raw(7), 32'h0);
  endtask

  task automatic t_owner;
    wr(mb(1, 'h00), 32'h01);
    rd_chk("R3 claim", mb(1, 'h00), 32'h01);
    wr(mb(1, 'h00), 32'h04);
    rd_chk("R3 second claim refused", mb(1, 'h00), 32'h01);
    wr(mb(1, 'h00), 32'h00);
    rd_chk("R3 release", mb(1, 'h00), 32'h00);
    wr(mb(1, 'h00), 32'h04);
    rd_chk("R3 reclaim", mb(1, 'h00), 32'h04);
    wr(mb(1, 'h00), 32'h00);
  endtask

  task automatic t_no_owner;
    wr(mb(2, 'h04), 32'hFF);
    wr(mb(2, 'h14), 32'hFF);
    wr(mb(2, 'h24), 32'hDEAD_BEEF);
    wr(mb(2, 'h20), 32'h1);
    rd_chk("R4 dest", mb(2, 'h0C), 32'h0);
    rd_chk("R4 mask", mb(2, 'h1C), 32'h0);
    rd_chk("R4 data", mb(2, 'h24), 32'h0);
    rd_chk("R4 control", mb(2, 'h20), 32'h0);
    chk("R4 irq", 32'(chan_irq), 32'h0);
  endtask

  task automatic t_setclr;
    wr(mb(3, 'h00), 32'h01);
    wr(mb(3, 'h04), 32'h06);
    wr(mb(3, 'h04), 32'h08);
    rd_chk("R5 dest set", mb(3, 'h0C), 32'h0E);
    wr(mb(3, 'h08), 32'h04);
    rd_chk("R5 dest clear", mb(3, 'h0C), 32'h0A);
    wr(mb(3, 'h14), 32'h03);
    wr(mb(3, 'h14), 32'h40);
    wr(mb(3, 'h18), 32'h40);
    rd_chk("R5 mask set/clear", mb(3, 'h1C), 32'h03);
  endtask

  task automatic t_data;
    for (int k = 0; k < 7; k++) wr(mb(3, 'h24 + 4 * k), 32'hA500_0000 + 32'(k * 17));
    for (int k = 0; k < 7; k++) rd_chk("R2 payload", mb(3, 'h24 + 4 * k), 32'hA500_0000 + 32'(k * 17));
    wr(mb(3, 'h10), 32'hFF);
    rd_chk("R2 mode reads zero", mb(3, 'h10), 32'h0);
  endtask

  task automatic t_post;
    // mb3: owner ch0, dest ch1+ch3, mask ch0+ch1
    wr(mb(3, 'h20), 32'h1);
    chk("R10 irq after post", 32'(chan_irq), 32'h02);
    rd_chk("R8 control reads 1", mb(3, 'h20), 32'h1);
    rd_chk("R6 raw ch1", st_raw(1), 32'h08);
    rd_chk("R6 raw ch3", st_raw(3), 32'h08);
    rd_chk("R9 masked ch1", st_msk(1), 32'h08);
    rd_chk("R9 masked ch3 filtered", st_msk(3), 32'h00);
    rd_chk("R6 owner raw quiet", st_raw(0), 32'h00);
  endtask

  task automatic t_ack;
    wr(mb(3, 'h20), 32'h2);
    chk("R10 irq after ack", 32'(chan_irq), 32'h01);
    rd_chk("R7 raw ch1 drops", st_raw(1), 32'h00);
    rd_chk("R7 raw ch0 rises", st_raw(0), 32'h08);
    rd_chk("R9 masked ch0", st_msk(0), 32'h08);
  endtask

  task automatic t_clear;
    wr(mb(3, 'h20), 32'h3);
    rd_chk("R8 code 3 ignored", mb(3, 'h20), 32'h2);
    chk("R8 irq kept", 32'(chan_irq), 32'h01);
    wr(mb(3, 'h20), 32'h0);
    chk("R8 irq withdrawn", 32'(chan_irq), 32'h00);
    rd_chk("R8 raw ch0 clear", st_raw(0), 32'h00);
  endtask

  task automatic t_multi;
    wr(mb(5, 'h00), 32'h10);
    wr(mb(5, 'h04), 32'h02);
    wr(mb(5, 'h14), 32'h02);
    wr(mb(5, 'h20), 32'h1);
    wr(mb(3, 'h20), 32'h1);
    rd_chk("R9 two mailboxes ch1", st_msk(1), 32'h28);
    wr(mb(3, 'h20), 32'h0);
    chk("R10 irq held by mb5", 32'(chan_irq), 32'h02);
    wr(mb(5, 'h18), 32'h02);
    chk("R10 mask clear drops irq", 32'(chan_irq), 32'h00);
    rd_chk("R9 raw ignores mask", st_raw(1), 32'h20);
    wr(mb(5, 'h20), 32'h0);
  endtask

  task automatic t_unmapped;
    wr(mb(3, 'h05), 32'hF0);
    rd_chk("R11 misaligned write", mb(3, 'h0C), 32'h0A);
    rd_chk("R11 misaligned read", mb(3, 'h0D), 32'h0);
    wr(mb(8, 'h00), 32'h01);
    rd_chk("R11 mailbox past end", mb(8, 'h00), 32'h0);
    rd_chk("R11 channel past end", 12'h840, 32'h0);
    wr(12'h804, 32'hFF);
    rd_chk("R11 status not writable", 12'h804, 32'h0);
    rd_chk("R11 gap", 12'h600, 32'h0);
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_owner();
    t_no_owner();
    t_setclr();
    t_data();
    t_post();
    t_ack();
    t_clear();
    t_multi();
    t_unmapped();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule